// File: doc/BRIEF.md
# Lockable Watchdog Timer with Reset-Cause Capture

This block is a watchdog timer that software controls through a single 32-bit control and status word on a plain synchronous bus. A write strobe with write data updates the word on a rising clock edge. The read data always shows the current contents. The word carries a timeout field counted in seconds, a run enable, a write-once freeze bit, a reload strobe and two sticky reset-cause flags. A prescaler divides the system clock into one-second ticks. When the countdown runs out, the block raises a reset request for a fixed number of clocks.

Once software sets the freeze bit, the enable bit, the timeout field and the freeze bit itself ignore all writes until power-on reset. Reloads are still accepted, so a frozen watchdog can still be serviced but can no longer be stopped or retuned. The cause flags and the freeze bit survive a warm reset, so after a watchdog-driven reboot software can tell why the system restarted.

A three-state controller sequences the countdown. In ST_IDLE the counter is stopped. When the enable bit is seen set, IDLE goes to ST_RUN and loads the committed timeout. RUN returns to IDLE when the enable bit is cleared. RUN goes to ST_FIRE when the last second elapses. FIRE holds the request for the pulse length and then goes to RUN, reloading the timeout, if still enabled, or to IDLE if not. A warm reset forces IDLE.

Top module: `wdl_top`

## Requirements
- R1: After power-on reset the read data equals the default timeout field (parameter TOV_RST, 59 by default) with every other bit 0, and rst_req is low.
- R2: Bits 9:0 hold the timeout field f. A countdown loaded with f expires (f+1)*TICK_CLKS clocks after the edge that loads it, so the period spans 1 to 1024 seconds.
- R3: Bit 14 is the enable. The countdown loads the committed timeout on the clock after the enable is seen set. Clearing the enable stops the countdown, and no reset request follows.
- R4: Writing 1 to bit 31 restarts the countdown on the write edge, using the timeout field as updated by that same write. Bit 31 always reads 0. A write with bit 31 at 0 does not restart a countdown.
- R5: A new timeout field written without a reload does not change a countdown already in progress. It is used at the next load.
- R6: Bit 12 is the freeze bit. Once it is written to 1 it stays 1 until power-on reset, and later writes to bits 14, 12 and 9:0 have no effect.
- R7: A reload written while frozen still restarts the countdown.
- R8: On expiry, rst_req is high for exactly PULSE_CLKS consecutive clocks and bit 24 becomes 1. If the block is still enabled, a new countdown is loaded when the pulse ends.
- R9: A one-clock pulse on cause_in sets bit 25. Writing 1 to bit 24 or bit 25 clears that flag. An expiry on the same edge takes precedence over the clear.
- R10: While warm_rst_n is low at a clock edge, the enable is cleared, the timeout field returns to TOV_RST and the countdown stops. The freeze bit and bits 24 and 25 keep their values. por_n clears everything.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Asynchronous power-on reset, active low; clears all state |
| warm_rst_n | input | 1 | Synchronous warm reset, active low; spares the freeze bit and cause flags |
| wr_en | input | 1 | Write strobe for the control word |
| wdata | input | 32 | Write data |
| cause_in | input | 1 | External expiry cause; sets bit 25 |
| rdata | output | 32 | Current control and status word |
| rst_req | output | 1 | Reset request pulse on expiry |

## Verification
The checker watches four things on every clock. The freeze bit must never fall outside power-on reset. The enable and the timeout field must hold still while frozen, except under warm reset. A rising reset request must come with bit 24 set. A request must never start while the enable is clear. Exact expiry cycles, which timeout a countdown commits, pulse length, restart after the pulse, reload under freeze, warm-reset retention and clearing of the cause flags depend on particular sequences of writes. The bench's directed scenarios and the table of timeout values cover these.

// File: rtl/wdl_pkg.sv
package wdl_pkg;
    localparam int WORD_W        = 32;
    localparam int TOV_W         = 10;
    localparam int TOV_LSB       = 0;
    localparam int FREEZE_BIT    = 12;
    localparam int RUN_EN_BIT    = 14;
    localparam int CAUSE_EXP_BIT = 24;
    localparam int CAUSE_ALT_BIT = 25;
    localparam int RELOAD_BIT    = 31;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIRE = 2'd2
    } wdl_state_e;
endpackage

// File: rtl/wdl_prescaler.sv
module wdl_prescaler #(
    parameter int TICK_CLKS = 1000
) (
    input  logic clk,
    input  logic por_n,
    input  logic restart,
    input  logic run,
    output logic tick
);
    localparam int CW = (TICK_CLKS > 1) ? $clog2(TICK_CLKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_CLKS - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            cnt_q <= '0;
        end else if (restart || !run || cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = run && !restart && (cnt_q == LAST);
endmodule

// File: rtl/wdl_ctrlreg.sv
module wdl_ctrlreg
    import wdl_pkg::*;
#(
    parameter int TOV_RST = 59
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              warm_rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wdata,
    input  logic              expire,
    input  logic              cause_in,
    output logic              run_en,
    output logic [TOV_W-1:0]  tov_cur,
    output logic [TOV_W-1:0]  tov_next,
    output logic              reload,
    output logic [WORD_W-1:0] rdata
);
    logic             en_q;
    logic [TOV_W-1:0] tov_q;
    logic             freeze_q;
    logic             cause_exp_q;
    logic             cause_alt_q;
    logic             open_wr;

    assign open_wr = wr_en && !freeze_q;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            en_q  <= 1'b0;
            tov_q <= TOV_W'(TOV_RST);
        end else if (!warm_rst_n) begin
            en_q  <= 1'b0;
            tov_q <= TOV_W'(TOV_RST);
        end else if (open_wr) begin
            en_q  <= wdata[RUN_EN_BIT];
            tov_q <= wdata[TOV_LSB +: TOV_W];
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            freeze_q <= 1'b0;
        end else if (warm_rst_n && wr_en && wdata[FREEZE_BIT]) begin
            freeze_q <= 1'b1;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            cause_exp_q <= 1'b0;
            cause_alt_q <= 1'b0;
        end else begin
            if (expire) begin
                cause_exp_q <= 1'b1;
            end else if (wr_en && wdata[CAUSE_EXP_BIT]) begin
                cause_exp_q <= 1'b0;
            end
            if (cause_in) begin
                cause_alt_q <= 1'b1;
            end else if (wr_en && wdata[CAUSE_ALT_BIT]) begin
                cause_alt_q <= 1'b0;
            end
        end
    end

    assign reload   = warm_rst_n && wr_en && wdata[RELOAD_BIT];
    assign tov_next = open_wr ? wdata[TOV_LSB +: TOV_W] : tov_q;
    assign tov_cur  = tov_q;
    assign run_en   = en_q;

    always_comb begin
        rdata                        = '0;
        rdata[TOV_LSB +: TOV_W]      = tov_q;
        rdata[FREEZE_BIT]            = freeze_q;
        rdata[RUN_EN_BIT]            = en_q;
        rdata[CAUSE_EXP_BIT]         = cause_exp_q;
        rdata[CAUSE_ALT_BIT]         = cause_alt_q;
    end

    logic unused_wbits;
    assign unused_wbits = ^{wdata[30:26], wdata[23:15], wdata[13], wdata[11:10]};
endmodule

// File: rtl/wdl_countdown.sv
module wdl_countdown
    import wdl_pkg::*;
#(
    parameter int PULSE_CLKS = 16
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             warm_rst_n,
    input  logic             run_en,
    input  logic [TOV_W-1:0] tov_cur,
    input  logic [TOV_W-1:0] tov_next,
    input  logic             reload,
    input  logic             tick,
    output logic             restart,
    output logic             running,
    output logic             expire,
    output logic             rst_req
);
    localparam int PW = (PULSE_CLKS > 1) ? $clog2(PULSE_CLKS) : 1;
    localparam logic [PW-1:0] PULSE_LAST = PW'(PULSE_CLKS - 1);
    localparam logic [TOV_W:0] ONE_SEC = (TOV_W + 1)'(1);

    wdl_state_e       state_q, state_d;
    logic [TOV_W:0]   secs_q;
    logic [PW-1:0]    pcnt_q;
    logic             load;
    logic [TOV_W-1:0] load_val;

    always_comb begin
        state_d  = state_q;
        load     = 1'b0;
        load_val = tov_cur;
        unique case (state_q)
            ST_IDLE: begin
                if (run_en) begin
                    state_d = ST_RUN;
                    load    = 1'b1;
                end
            end
            ST_RUN: begin
                if (!run_en) begin
                    state_d = ST_IDLE;
                end else if (reload) begin
                    load     = 1'b1;
                    load_val = tov_next;
                end else if (tick && secs_q == ONE_SEC) begin
                    state_d = ST_FIRE;
                end
            end
            ST_FIRE: begin
                if (pcnt_q == PULSE_LAST) begin
                    if (run_en) begin
                        state_d = ST_RUN;
                        load    = 1'b1;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state_q <= ST_IDLE;
        end else if (!warm_rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            secs_q <= '0;
            pcnt_q <= '0;
        end else begin
            if (load) begin
                secs_q <= {1'b0, load_val} + ONE_SEC;
            end else if (state_q == ST_RUN && tick) begin
                secs_q <= secs_q - ONE_SEC;
            end
            if (state_q == ST_FIRE) begin
                pcnt_q <= pcnt_q + 1'b1;
            end else begin
                pcnt_q <= '0;
            end
        end
    end

    always_comb begin
        restart = load && warm_rst_n;
        running = (state_q == ST_RUN);
        expire  = warm_rst_n && (state_q == ST_RUN) && (state_d == ST_FIRE);
        rst_req = (state_q == ST_FIRE);
    end
endmodule

// File: rtl/wdl_top.sv
module wdl_top
    import wdl_pkg::*;
#(
    parameter int TICK_CLKS  = 1000000,
    parameter int PULSE_CLKS = 16,
    parameter int TOV_RST    = 59
) (
    input  logic        clk,
    input  logic        por_n,
    input  logic        warm_rst_n,
    input  logic        wr_en,
    input  logic [31:0] wdata,
    input  logic        cause_in,
    output logic [31:0] rdata,
    output logic        rst_req
);
    logic             run_en;
    logic [TOV_W-1:0] tov_cur;
    logic [TOV_W-1:0] tov_next;
    logic             reload;
    logic             expire;
    logic             restart;
    logic             running;
    logic             tick;

    wdl_ctrlreg #(.TOV_RST(TOV_RST)) u_reg (
        .clk        (clk),
        .por_n      (por_n),
        .warm_rst_n (warm_rst_n),
        .wr_en      (wr_en),
        .wdata      (wdata),
        .expire     (expire),
        .cause_in   (cause_in),
        .run_en     (run_en),
        .tov_cur    (tov_cur),
        .tov_next   (tov_next),
        .reload     (reload),
        .rdata      (rdata)
    );

    wdl_prescaler #(.TICK_CLKS(TICK_CLKS)) u_pre (
        .clk     (clk),
        .por_n   (por_n),
        .restart (restart),
        .run     (running),
        .tick    (tick)
    );

    wdl_countdown #(.PULSE_CLKS(PULSE_CLKS)) u_cnt (
        .clk        (clk),
        .por_n      (por_n),
        .warm_rst_n (warm_rst_n),
        .run_en     (run_en),
        .tov_cur    (tov_cur),
        .tov_next   (tov_next),
        .reload     (reload),
        .tick       (tick),
        .restart    (restart),
        .running    (running),
        .expire     (expire),
        .rst_req    (rst_req)
    );
endmodule

// File: rtl/wdl_checker.sv
module wdl_checker (
    input logic        clk,
    input logic        por_n,
    input logic        warm_rst_n,
    input logic [31:0] rdata,
    input logic        rst_req
);
    // R6: the freeze bit never falls while power stays up
    a_r6_freeze_sticky: assert property (@(posedge clk) disable iff (!por_n)
        rdata[12] |=> rdata[12]);

    // R6: frozen enable and timeout hold unless a warm reset is applied
    a_r6_frozen_fields: assert property (@(posedge clk) disable iff (!por_n)
        (rdata[12] && warm_rst_n) |=> ($stable(rdata[14]) && $stable(rdata[9:0])));

    // R8: a starting request always comes with the expiry cause flag
    a_r8_cause_on_fire: assert property (@(posedge clk) disable iff (!por_n)
        $rose(rst_req) |-> rdata[24]);

    // R3: no request can begin while the enable is clear
    a_r3_no_fire_disabled: assert property (@(posedge clk) disable iff (!por_n)
        !rdata[14] |=> !$rose(rst_req));
endmodule

bind wdl_top wdl_checker u_chk (
    .clk        (clk),
    .por_n      (por_n),
    .warm_rst_n (warm_rst_n),
    .rdata      (rdata),
    .rst_req    (rst_req)
);

// File: tb/wdl_top_tb_top.sv
module wdl_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int TICK       = 4;
    localparam int PULSE      = 4;
    localparam int TOV_DEF    = 59;
    localparam logic [31:0] EN  = 32'h0000_4000;
    localparam logic [31:0] FRZ = 32'h0000_1000;
    localparam logic [31:0] RLD = 32'h8000_0000;
    localparam logic [31:0] C24 = 32'h0100_0000;
    localparam logic [31:0] C25 = 32'h0200_0000;
    localparam int NVEC = 4;
    // timeout field, and clocks from enable write to first request cycle: (f+1)*TICK+1
    localparam int VEC_TOV [NVEC] = '{0, 1, 2, 5};
    localparam int VEC_EXP [NVEC] = '{5, 9, 13, 25};

    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        warm_rst_n = 1'b1;
    logic        wr_en = 1'b0;
    logic [31:0] wdata = '0;
    logic        cause_in = 1'b0;
    logic [31:0] rdata;
    logic        rst_req;
    int checks = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wdl_top #(.TICK_CLKS(TICK), .PULSE_CLKS(PULSE), .TOV_RST(TOV_DEF)) dut_i (
        .clk(clk), .por_n(por_n), .warm_rst_n(warm_rst_n), .wr_en(wr_en),
        .wdata(wdata), .cause_in(cause_in), .rdata(rdata), .rst_req(rst_req)
    );

    task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [31:0] d);
        wr_en = 1'b1;
        wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
        wdata = '0;
    endtask

    task automatic req_at(input int k, input string req);
        run(k - 1);
        check(rst_req == 1'b0, req, {31'b0, rst_req}, 32'h0);
        run(1);
        check(rst_req == 1'b1, req, {31'b0, rst_req}, 32'h1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int hi;
        run(3);
        por_n = 1'b1;
        run(2);
        // R1 reset state
        check(rdata == 32'd59, "R1", rdata, 32'd59);
        check(rst_req == 1'b0, "R1", {31'b0, rst_req}, 32'h0);

        // R2 / R3: table of timeouts started by enable
        for (int i = 0; i < NVEC; i++) begin
            wr(EN | 32'(VEC_TOV[i]));
            req_at(VEC_EXP[i], "R2");
            wr(32'h0);
            run(PULSE + 2);
        end

        // R5 / R4: timeout change without reload leaves countdown alone
        wr(EN | 32'd3);
        run(6);
        wr(EN | 32'd1);
        req_at(10, "R5");
        // R8: pulse length, cause flag, restart with committed field 1
        run(PULSE - 1);
        check(rst_req == 1'b1, "R8", {31'b0, rst_req}, 32'h1);
        run(1);
        check(rst_req == 1'b0, "R8", {31'b0, rst_req}, 32'h0);
        check(rdata[24] == 1'b1, "R8", rdata, 32'h0100_4001);
        req_at(8, "R8");
        wr(32'h0);
        run(PULSE + 2);
        // R9: clear expiry flag by writing 1 to bit 24
        wr(C24);
        check(rdata[24] == 1'b0, "R9", rdata, 32'h0);

        // R4: reload restarts countdown; bit 31 reads 0
        wr(EN | 32'd3);
        run(10);
        wr(RLD | EN | 32'd3);
        check(rdata[31] == 1'b0, "R4", rdata, 32'h0000_4003);
        req_at(16, "R4");
        wr(32'h0);
        run(PULSE + 2);

        // R3: clearing enable stops countdown
        wr(EN | 32'd1);
        run(4);
        wr(32'h0);
        hi = 0;
        for (int i = 0; i < 20; i++) begin
            run(1);
            if (rst_req) hi++;
        end
        check(hi == 0, "R3", 32'(hi), 32'h0);

        // R9: external cause sets bit 25, write 1 clears it
        @(negedge clk);
        cause_in = 1'b1;
        @(negedge clk);
        cause_in = 1'b0;
        check(rdata[25] == 1'b1, "R9", rdata, C25);
        wr(C25);
        check(rdata[25] == 1'b0, "R9", rdata, 32'h0);
        wr(C24);

        // R6 / R7: freeze, attempts to change, reload while frozen
        wr(FRZ | EN | 32'd2);
        run(3);
        wr(32'h0);
        check(rdata == (FRZ | EN | 32'd2), "R6", rdata, FRZ | EN | 32'd2);
        wr(RLD);
        req_at(12, "R7");
        wr(EN | 32'd5);
        check(rdata[9:0] == 10'd2 && rdata[12], "R6", rdata, 32'h0100_5002);
        run(PULSE + 2);

        // R10: warm reset keeps freeze and cause, clears enable and field
        @(negedge clk);
        warm_rst_n = 1'b0;
        @(negedge clk);
        warm_rst_n = 1'b1;
        check(rdata == (C24 | FRZ | 32'd59), "R10", rdata, C24 | FRZ | 32'd59);
        run(20);
        check(rst_req == 1'b0, "R10", {31'b0, rst_req}, 32'h0);
        // R10: power-on reset clears everything
        @(negedge clk);
        por_n = 1'b0;
        @(negedge clk);
        por_n = 1'b1;
        check(rdata == 32'd59, "R10", rdata, 32'd59);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule